// File: doc/BRIEF.md
# Display Timing Interrupt Generator

This block keeps the raster position of a display: a dot counter that steps on a clock-enable input and a line counter that steps whenever a line's dot periods are used up. Each line begins with a drawing span and ends with a blank span. The first lines of a frame are visible and the rest form the vertical-blank span. From this position the block makes three single-cycle event pulses for an interrupt controller's pending inputs. One fires on entry to the vertical-blank span, one on entry to the blank span of each line, and one at the start of a chosen line.

Software sees a 16-bit status word. The upper byte is the line number to compare against. Three writable bits enable the three events, each on its own. Three read-only bits show whether the display is in vertical blank, whether it is in horizontal blank, and whether the current line equals the compare value. A second 16-bit read port returns the live line number. By default a line has 308 dot periods, 240 of them drawing, and a frame has 228 lines, 160 of them visible.

Top module: `dt_irq_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, the line read port is 0 and all three event outputs are 0. The status word reads 0x0004: compare 0, enables 0, and the line-match flag (bit 2) set because line 0 equals compare 0.
- R2: The line counter counts 0 up to TOTAL_LINES-1 and then wraps to 0. It steps once for every DOTS_PER_LINE enabled dot periods. The line read port shows it zero-extended to 16 bits.
- R3: In a cycle where dot_en is low, neither counter moves and no event is produced.
- R4: Status bit 1 (in horizontal blank) is 1 exactly while the dot index is DRAW_DOTS or higher, on every line.
- R5: Status bit 0 (in vertical blank) is 1 exactly while the line index is VISIBLE_LINES or higher.
- R6: Status bit 2 (line match) is 1 exactly while the line index equals status bits 15:8.
- R7: A write to the status word stores bits 15:8 (compare line) and bits 5:3 (enables: bit 3 vertical blank, bit 4 horizontal blank, bit 5 line match). Written values of bits 7:6 and 2:0 are ignored: bits 7:6 read 0 and bits 2:0 keep showing the live flags.
- R8: irq_hblank pulses for one cycle on the dot step into index DRAW_DOTS, on every line including vertical-blank lines, when bit 4 is set.
- R9: irq_vblank pulses for one cycle on the step into line VISIBLE_LINES, dot 0, when bit 3 is set.
- R10: irq_match pulses for one cycle on the step into dot 0 of a line equal to the compare value, including the wrap into line 0, when bit 5 is set. Writing a compare value equal to the current line mid-line gives no pulse, and a compare value above the last line never matches.
- R11: An event whose enable bit was clear at the step gives no pulse.
- R12: No event output is high in two consecutive cycles. Each pulse appears in the same cycle as the new counter value that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-period clock enable |
| stat_wr | input | 1 | Status-word write strobe |
| stat_wdata | input | 16 | Status-word write data |
| stat_rdata | output | 16 | Status word: compare, enables, live flags |
| line_rdata | output | 16 | Current line, zero-extended |
| irq_vblank | output | 1 | Vertical-blank entry pulse |
| irq_hblank | output | 1 | Horizontal-blank entry pulse |
| irq_match | output | 1 | Line-compare match pulse |

## Verification
The bench uses a shrunk raster so that whole frames fit in a few hundred cycles, and it models the raster arithmetically. It probes the frame wrap, where a compare value of 0 must still fire a match and a counter that ran one line too far would report a line that does not exist. It checks horizontal blank on vertical-blank lines, which a design that tied it to visible lines would miss by emitting too few pulses per frame. It writes a compare value equal to the current line in mid-line, which a level-triggered match would turn into a spurious pulse. It also runs gapped enables, which expose counters that move without dot_en, and cleared enables, which expose a gate that does not apply.

// File: rtl/dt_pkg.sv
package dt_pkg;

    // Status word bit positions (behavioural: software decodes them)
    localparam int FLAG_VBL_BIT  = 0;
    localparam int FLAG_HBL_BIT  = 1;
    localparam int FLAG_CMP_BIT  = 2;
    localparam int EN_VBL_BIT    = 3;
    localparam int EN_HBL_BIT    = 4;
    localparam int EN_CMP_BIT    = 5;
    localparam int CMP_LSB       = 8;
    localparam int CMP_W         = 8;
    localparam int STAT_W        = 16;
    localparam int N_EVT         = 3;

    // One bit per event kind; packed order gives match=2, hblank=1, vblank=0
    typedef struct packed {
        logic match;
        logic hblank;
        logic vblank;
    } evt_set_t;

    typedef struct packed {
        logic [CMP_W-1:0] cmp_line;
        evt_set_t         enables;
    } stat_cfg_t;

    function automatic logic [STAT_W-1:0] stat_pack(stat_cfg_t cfg, evt_set_t flags);
        return {cfg.cmp_line, 2'b00, cfg.enables, flags};
    endfunction

    function automatic stat_cfg_t stat_unpack(logic [STAT_W-1:0] w);
        stat_cfg_t c;
        c.cmp_line = w[CMP_LSB +: CMP_W];
        c.enables  = evt_set_t'(w[EN_CMP_BIT:EN_VBL_BIT]);
        return c;
    endfunction

endpackage

// File: rtl/dt_raster_cnt.sv
module dt_raster_cnt
    import dt_pkg::*;
#(
    parameter int DOTS_PER_LINE = 308,
    parameter int DRAW_DOTS     = 240,
    parameter int VISIBLE_LINES = 160,
    parameter int TOTAL_LINES   = 228,
    localparam int DOT_W        = $clog2(DOTS_PER_LINE),
    localparam int LINE_W       = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_en,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] line_nxt_o,
    output evt_set_t          step_o,
    output logic              in_vblank_o,
    output logic              in_hblank_o
);

    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [DOT_W-1:0]  DRAW_LAST = DOT_W'(DRAW_DOTS - 1);
    localparam logic [DOT_W-1:0]  DRAW_END  = DOT_W'(DRAW_DOTS);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_LAST  = LINE_W'(VISIBLE_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VISIBLE_LINES);

    logic [DOT_W-1:0]  dot_q, dot_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              line_wrap;

    assign line_wrap = dot_en && (dot_q == DOT_LAST);

    always_comb begin
        dot_d  = dot_q;
        line_d = line_q;
        if (dot_en) begin
            if (dot_q == DOT_LAST) begin
                dot_d  = '0;
                line_d = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
            end else begin
                dot_d = dot_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dot_q  <= '0;
            line_q <= '0;
        end else begin
            dot_q  <= dot_d;
            line_q <= line_d;
        end
    end

    // Step strobes: true in the cycle whose edge moves into the new region
    always_comb begin
        step_o.hblank = dot_en && (dot_q == DRAW_LAST);
        step_o.vblank = line_wrap && (line_q == VIS_LAST);
        step_o.match  = line_wrap;
    end

    assign dot_o       = dot_q;
    assign line_o      = line_q;
    assign line_nxt_o  = line_d;
    assign in_hblank_o = (dot_q >= DRAW_END);
    assign in_vblank_o = (line_q >= VIS_END);

endmodule

// File: rtl/dt_stat_reg.sv
module dt_stat_reg
    import dt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output stat_cfg_t         cfg_o
);

    stat_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= stat_unpack(wdata);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dt_event_gen.sv
module dt_event_gen
    import dt_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_set_t          step,
    input  stat_cfg_t         cfg,
    input  logic [LINE_W-1:0] line_nxt,
    output evt_set_t          evt_o
);

    logic [N_EVT-1:0] qual;
    logic [N_EVT-1:0] fire_d;
    logic [N_EVT-1:0] fire_q;
    logic             cmp_hit;

    assign cmp_hit = (CMP_W'(line_nxt) == cfg.cmp_line);

    always_comb begin
        qual = '1;
        qual[EN_CMP_BIT - EN_VBL_BIT] = cmp_hit;
    end

    for (genvar g = 0; g < N_EVT; g++) begin : g_lane
        assign fire_d[g] = step[g] && cfg.enables[g] && qual[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                fire_q[g] <= 1'b0;
            end else begin
                fire_q[g] <= fire_d[g];
            end
        end
    end

    assign evt_o = evt_set_t'(fire_q);

endmodule

// File: rtl/dt_irq_gen.sv
module dt_irq_gen
    import dt_pkg::*;
#(
    parameter int DOTS_PER_LINE = 308,
    parameter int DRAW_DOTS     = 240,
    parameter int VISIBLE_LINES = 160,
    parameter int TOTAL_LINES   = 228
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dot_en,
    input  logic        stat_wr,
    input  logic [15:0] stat_wdata,
    output logic [15:0] stat_rdata,
    output logic [15:0] line_rdata,
    output logic        irq_vblank,
    output logic        irq_hblank,
    output logic        irq_match
);

    localparam int DOT_W  = $clog2(DOTS_PER_LINE);
    localparam int LINE_W = $clog2(TOTAL_LINES);

    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line, line_nxt;
    evt_set_t          step, flags, evt;
    stat_cfg_t         cfg;
    logic              in_vblank, in_hblank;

    dt_raster_cnt #(
        .DOTS_PER_LINE (DOTS_PER_LINE),
        .DRAW_DOTS     (DRAW_DOTS),
        .VISIBLE_LINES (VISIBLE_LINES),
        .TOTAL_LINES   (TOTAL_LINES)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .dot_en      (dot_en),
        .dot_o       (dot),
        .line_o      (line),
        .line_nxt_o  (line_nxt),
        .step_o      (step),
        .in_vblank_o (in_vblank),
        .in_hblank_o (in_hblank)
    );

    dt_stat_reg u_stat (
        .clk   (clk),
        .rst   (rst),
        .wr    (stat_wr),
        .wdata (stat_wdata),
        .cfg_o (cfg)
    );

    dt_event_gen #(
        .LINE_W (LINE_W)
    ) u_evt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .cfg      (cfg),
        .line_nxt (line_nxt),
        .evt_o    (evt)
    );

    logic unused_dot;
    assign unused_dot = ^dot;

    always_comb begin
        flags.vblank = in_vblank;
        flags.hblank = in_hblank;
        flags.match  = (CMP_W'(line) == cfg.cmp_line);
    end

    assign stat_rdata = stat_pack(cfg, flags);
    assign line_rdata = 16'(line);
    assign irq_vblank = evt.vblank;
    assign irq_hblank = evt.hblank;
    assign irq_match  = evt.match;

endmodule

// File: rtl/dt_irq_gen_chk.sv
module dt_irq_gen_chk #(
    parameter int TOTAL_LINES = 228
) (
    input logic        clk,
    input logic        rst,
    input logic        dot_en,
    input logic [15:0] stat_rdata,
    input logic [15:0] line_rdata,
    input logic        irq_vblank,
    input logic        irq_hblank,
    input logic        irq_match
);

    assert_line_range_R2: assert property (@(posedge clk) disable iff (rst)
        line_rdata < 16'(TOTAL_LINES));

    assert_hold_no_en_R3: assert property (@(posedge clk) disable iff (rst)
        !dot_en |=> $stable(line_rdata) && $stable(stat_rdata[1:0])
                    && !irq_hblank && !irq_vblank && !irq_match);

    assert_hbl_entry_R8: assert property (@(posedge clk) disable iff (rst)
        irq_hblank |-> stat_rdata[1] && !$past(stat_rdata[1]));

    assert_vbl_entry_R9: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |-> stat_rdata[0] && !$past(stat_rdata[0]));

    assert_match_line_start_R10: assert property (@(posedge clk) disable iff (rst)
        irq_match |-> (line_rdata[7:0] == $past(stat_rdata[15:8]))
                      && (line_rdata != $past(line_rdata)));

    assert_hbl_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq_hblank |-> $past(stat_rdata[4]));

    assert_vbl_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |-> $past(stat_rdata[3]));

    assert_match_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq_match |-> $past(stat_rdata[5]));

    assert_hbl_onecycle_R12: assert property (@(posedge clk) disable iff (rst)
        irq_hblank |=> !irq_hblank);

    assert_vbl_onecycle_R12: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |=> !irq_vblank);

    assert_match_onecycle_R12: assert property (@(posedge clk) disable iff (rst)
        irq_match |=> !irq_match);

endmodule

bind dt_irq_gen dt_irq_gen_chk #(
    .TOTAL_LINES (TOTAL_LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dot_en     (dot_en),
    .stat_rdata (stat_rdata),
    .line_rdata (line_rdata),
    .irq_vblank (irq_vblank),
    .irq_hblank (irq_hblank),
    .irq_match  (irq_match)
);

// File: tb/dt_irq_gen_bench.sv
module dt_irq_gen_bench;

    localparam int DOTS  = 10;
    localparam int DRAW  = 6;
    localparam int VIS   = 5;
    localparam int LINES = 8;
    localparam int FRAME = DOTS * LINES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dot_en = 1'b0;
    logic        stat_wr = 1'b0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata, line_rdata;
    logic        irq_vblank, irq_hblank, irq_match;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Arithmetic model of the raster and status word
    int   m_dot = 0, m_line = 0, m_cmp = 0;
    logic m_env = 0, m_enh = 0, m_enm = 0;
    int   n_v = 0, n_h = 0, n_m = 0;

    always #2.5 clk = ~clk;

    dt_irq_gen #(
        .DOTS_PER_LINE (DOTS),
        .DRAW_DOTS     (DRAW),
        .VISIBLE_LINES (VIS),
        .TOTAL_LINES   (LINES)
    ) u_dt_irq_gen (
        .clk        (clk),
        .rst        (rst),
        .dot_en     (dot_en),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .stat_rdata (stat_rdata),
        .line_rdata (line_rdata),
        .irq_vblank (irq_vblank),
        .irq_hblank (irq_hblank),
        .irq_match  (irq_match)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_stat();
        logic [15:0] s;
        s = {m_cmp[7:0], 2'b00, m_enm, m_enh, m_env,
             logic'(m_line == m_cmp), logic'(m_dot >= DRAW), logic'(m_line >= VIS)};
        return s;
    endfunction

    task automatic tick(input logic en, input logic wr, input logic [15:0] wd);
        logic eh, ev, em, wrap;
        dot_en = en; stat_wr = wr; stat_wdata = wd;
        @(posedge clk);
        #1;
        eh   = en && (m_dot == DRAW - 1) && m_enh;
        wrap = en && (m_dot == DOTS - 1);
        ev   = wrap && (m_line == VIS - 1) && m_env;
        if (en) begin
            if (wrap) begin
                m_dot  = 0;
                m_line = (m_line == LINES - 1) ? 0 : m_line + 1;
            end else begin
                m_dot = m_dot + 1;
            end
        end
        em = wrap && (m_line == m_cmp) && m_enm;
        if (wr) begin
            m_cmp = int'(wd[15:8]);
            m_env = wd[3]; m_enh = wd[4]; m_enm = wd[5];
        end
        check("R2/R3 line", line_rdata, 16'(m_line));
        check("R4/R5/R6/R7 status", stat_rdata, exp_stat());
        check("R8/R11/R12 hblank", {15'd0, irq_hblank}, {15'd0, eh});
        check("R9/R11/R12 vblank", {15'd0, irq_vblank}, {15'd0, ev});
        check("R10/R11/R12 match", {15'd0, irq_match}, {15'd0, em});
        n_h += int'(irq_hblank); n_v += int'(irq_vblank); n_m += int'(irq_match);
        @(negedge clk);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick((gap == 0) || ((i % gap) != 1), 1'b0, 16'h0000);
        end
    endtask

    task automatic clr_counts();
        n_h = 0; n_v = 0; n_m = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 stat", stat_rdata, 16'h0004);
        check("R1 line", line_rdata, 16'h0000);
        check("R1 irqs", {13'd0, irq_vblank, irq_hblank, irq_match}, 16'h0000);
        rst = 1'b0;
        tick(1'b0, 1'b0, 16'h0000);
        check("R1 first cycle", stat_rdata, 16'h0004);

        // R7: write all ones in low byte; read-only and unused bits ignored
        tick(1'b0, 1'b1, 16'h03FF);
        check("R7 readback", stat_rdata, 16'h0338);

        // Two full frames, all events enabled, compare line 3
        clr_counts();
        run(2 * FRAME, 0);
        check("R8 hblank per 2 frames", 16'(n_h), 16'(2 * LINES));
        check("R9 vblank per 2 frames", 16'(n_v), 16'd2);
        check("R10 match per 2 frames", 16'(n_m), 16'd2);

        // R3: gapped enable, one third of cycles idle
        clr_counts();
        run(3 * FRAME, 3);
        check("R3 gapped hblank count", 16'(n_h), 16'(2 * LINES));

        // R11: everything disabled
        tick(1'b1, 1'b1, 16'h0300);
        clr_counts();
        run(FRAME, 0);
        check("R11 no pulses", 16'(n_h + n_v + n_m), 16'd0);

        // R10: compare 0, wrap into line 0 fires
        tick(1'b1, 1'b1, 16'h0020);
        clr_counts();
        run(FRAME, 0);
        check("R10 wrap match", 16'(n_m), 16'd1);

        // R10: mid-line write of compare equal to current line
        while (!(m_line == 2 && m_dot == 3)) tick(1'b1, 1'b0, 16'h0000);
        tick(1'b1, 1'b1, 16'h0220);
        clr_counts();
        run(DOTS - 5, 0);
        check("R10 no mid-line match", 16'(n_m), 16'd0);
        clr_counts();
        run(FRAME, 0);
        check("R10 match next frame", 16'(n_m), 16'd1);

        // R10: compare beyond last line never matches
        tick(1'b1, 1'b1, 16'hC820);
        clr_counts();
        run(FRAME, 0);
        check("R10 out-of-range compare", 16'(n_m), 16'd0);

        // R8: hblank only, confirms vblank-line hblanks
        tick(1'b1, 1'b1, 16'h0010);
        clr_counts();
        run(FRAME, 0);
        check("R8 hblank only", 16'(n_h), 16'(LINES));
        check("R11 others silent", 16'(n_v + n_m), 16'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule